// File: doc/BRIEF.md
# Packed Dual-Lane FIR Multiply-Accumulate Engine

This block produces one output of a finite impulse response filter per start pulse. On an accepted start it stores the new input sample into an external circular history memory, then walks the coefficient and history memories two taps at a time. Each coefficient word carries two signed 16-bit taps and each history read returns two signed 16-bit samples packed the same way, so every read cycle feeds two multipliers.

The product of the low halves goes into an even accumulator and the product of the high halves goes into a separate odd accumulator. Both accumulators are 40 bits wide and are cleared at the start of each output. They are summed only once, at the end, and the low 16 bits of that sum become the result. A one-cycle strobe marks the result. A start that arrives while an output is still being computed is dropped.

The tap count `TAPS` must be even. The history memory holds `2**HAW` samples, and `2**HAW` must be at least `TAPS`.

Top module: `fir_pair_mac`

## Requirements
- R1: Coefficient word `i` holds tap `2i` in bits [15:0] and tap `2i+1` in bits [31:16]. The history read data holds the entry at `smp_addr_lo` in bits [15:0] and the entry at `smp_addr_hi` in bits [31:16]. Both memories return data on the clock cycle after a cycle with `rd_en` high.
- R2: Each returned pair is multiplied as signed 16x16 values, low half by low half and high half by high half, giving two products per cycle.
- R3: Each output uses exactly `TAPS/2` consecutive read cycles, with `coef_addr` going 0, 1, …, `TAPS/2-1` in that order.
- R4: In read cycle `i`, `smp_addr_lo` equals (h − 2i) mod 2**HAW and `smp_addr_hi` equals (h − 2i − 1) mod 2**HAW. Here h is the write address of the sample stored by that start.
- R5: An accepted start drives `hist_we` high in the same cycle, with `hist_wdata = sample_in` and `hist_waddr` equal to a write pointer. The pointer is 0 after reset, steps by one per accepted start, and wraps modulo 2**HAW. `hist_we` is low in every other cycle.
- R6: The accumulators are cleared for every output. The result equals the low 16 bits of the exact sum over j of tap(j)·x(n−j), where x(n) is the newest sample.
- R7: `y_valid` is high for exactly one cycle, `TAPS/2+2` cycles after the accepted start. `y_out` holds the result from that cycle until the cycle after the next accepted start.
- R8: A start in any cycle from the one after an accepted start up to the one before its `y_valid` is ignored: it causes no history write and no extra output. A start in the `y_valid` cycle is accepted.
- R9: With taps 2, 1, 1, 1 (remaining taps zero), the result is 2x(n) + x(n−1) + x(n−2) + x(n−3).
- R10: After reset, `y_valid`, `rd_en` and `hist_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one output, using `sample_in` as the newest sample |
| sample_in | input | DW | New signed input sample |
| hist_we | output | 1 | History memory write enable |
| hist_waddr | output | HAW | History write address |
| hist_wdata | output | DW | History write data |
| rd_en | output | 1 | Read enable for both memories |
| coef_addr | output | CAW | Coefficient word address |
| coef_rdata | input | 2*DW | Packed coefficient pair |
| smp_addr_lo | output | HAW | History address for the low lane |
| smp_addr_hi | output | HAW | History address for the high lane |
| smp_rdata | input | 2*DW | Packed sample pair |
| y_out | output | DW | Truncated filter result |
| y_valid | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that both memories answer one cycle after a read cycle. They also assume that the coefficient memory stays unchanged while an output is being computed, and that nothing other than this block writes the history memory. The bench keeps to these assumptions. Its memory models register their read data on the same edge that the block samples its addresses. It rewrites coefficients only after waiting longer than one full output. It also holds `start` high for long runs, including across the `y_valid` cycle, so that acceptance and rejection both occur.

// File: rtl/fir_pair_pkg.sv
package fir_pair_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } fir_state_e;

endpackage

// File: rtl/fir_pair_seq.sv
module fir_pair_seq
  import fir_pair_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int HAW  = 4,
  localparam int HALF = TAPS / 2,
  localparam int CAW  = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int IW   = $clog2(HALF + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           accept,
  output logic [HAW-1:0] wr_ptr,
  output logic           rd_en,
  output logic [CAW-1:0] coef_addr,
  output logic [HAW-1:0] smp_addr_lo,
  output logic [HAW-1:0] smp_addr_hi,
  output logic           acc_en,
  output logic           done
);

  fir_state_e     state_q, state_nx;
  logic [IW-1:0]  iter_q, iter_nx;
  logic [HAW-1:0] head_q, head_nx;
  logic [HAW-1:0] rptr_q, rptr_nx;
  logic [CAW-1:0] caddr_q, caddr_nx;
  logic           rvld_q, rvld_nx;
  logic           done_q, done_nx;
  logic           ce_loop;

  // Handshake into the engine: only an idle engine takes a start.
  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_nx = state_q;
    iter_nx  = iter_q;
    head_nx  = head_q;
    rptr_nx  = rptr_q;
    caddr_nx = caddr_q;
    ce_loop  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_nx = ST_ISSUE;
          iter_nx  = IW'(HALF);
          head_nx  = head_q + 1'b1;
          rptr_nx  = head_q;
          caddr_nx = '0;
          ce_loop  = 1'b1;
        end
      end
      ST_ISSUE: begin
        ce_loop  = 1'b1;
        iter_nx  = iter_q - 1'b1;
        rptr_nx  = rptr_q - HAW'(2);
        caddr_nx = caddr_q + 1'b1;
        if (iter_q == IW'(1)) begin
          state_nx = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        state_nx = ST_IDLE;
      end
      default: begin
        state_nx = ST_IDLE;
      end
    endcase
    rvld_nx = (state_q == ST_ISSUE);
    done_nx = (state_q == ST_DRAIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
      rvld_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      head_q  <= head_nx;
      rvld_q  <= rvld_nx;
      done_q  <= done_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q  <= '0;
      rptr_q  <= '0;
      caddr_q <= '0;
    end else if (ce_loop) begin
      iter_q  <= iter_nx;
      rptr_q  <= rptr_nx;
      caddr_q <= caddr_nx;
    end
  end

  assign wr_ptr      = head_q;
  assign rd_en       = (state_q == ST_ISSUE);
  assign coef_addr   = caddr_q;
  assign smp_addr_lo = rptr_q;
  assign smp_addr_hi = rptr_q - 1'b1;
  assign acc_en      = rvld_q;
  assign done        = done_q;

endmodule

// File: rtl/fir_pair_lane.sv
module fir_pair_lane #(
  parameter int DW   = 16,
  parameter int ACCW = 40,
  localparam int PW  = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [DW-1:0]   coef,
  input  logic [DW-1:0]   smp,
  output logic [ACCW-1:0] acc
);

  logic signed [PW-1:0] prod;
  logic [ACCW-1:0]      prod_ext;
  logic [ACCW-1:0]      acc_q, acc_nx;
  logic                 ce;

  assign prod     = $signed(coef) * $signed(smp);
  assign prod_ext = {{(ACCW - PW){prod[PW-1]}}, prod};

  // Clear wins over accumulate; they never coincide in normal use.
  always_comb begin
    ce     = clr || en;
    acc_nx = clr ? '0 : (acc_q + prod_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (ce) begin
      acc_q <= acc_nx;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/fir_pair_merge.sv
module fir_pair_merge #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic [ACCW-1:0] acc_even,
  input  logic [ACCW-1:0] acc_odd,
  output logic [DW-1:0]   result
);

  logic [ACCW-1:0] total;

  assign total  = acc_even + acc_odd;
  assign result = total[DW-1:0];

endmodule

// File: rtl/fir_pair_mac.sv
module fir_pair_mac #(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int HAW  = 4,
  parameter int ACCW = 40,
  localparam int HALF = TAPS / 2,
  localparam int CAW  = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     sample_in,
  output logic              hist_we,
  output logic [HAW-1:0]    hist_waddr,
  output logic [DW-1:0]     hist_wdata,
  output logic              rd_en,
  output logic [CAW-1:0]    coef_addr,
  input  logic [2*DW-1:0]   coef_rdata,
  output logic [HAW-1:0]    smp_addr_lo,
  output logic [HAW-1:0]    smp_addr_hi,
  input  logic [2*DW-1:0]   smp_rdata,
  output logic [DW-1:0]     y_out,
  output logic              y_valid
);

  logic            accept;
  logic            acc_en;
  logic [ACCW-1:0] lane_acc [LANES];

  fir_pair_seq #(
    .TAPS (TAPS),
    .HAW  (HAW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .accept      (accept),
    .wr_ptr      (hist_waddr),
    .rd_en       (rd_en),
    .coef_addr   (coef_addr),
    .smp_addr_lo (smp_addr_lo),
    .smp_addr_hi (smp_addr_hi),
    .acc_en      (acc_en),
    .done        (y_valid)
  );

  assign hist_we    = accept;
  assign hist_wdata = sample_in;

  // Lane 0 takes the low halves (even taps), lane 1 the high halves (odd taps).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fir_pair_lane #(
      .DW   (DW),
      .ACCW (ACCW)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .en    (acc_en),
      .coef  (coef_rdata[g*DW +: DW]),
      .smp   (smp_rdata[g*DW +: DW]),
      .acc   (lane_acc[g])
    );
  end

  fir_pair_merge #(
    .DW   (DW),
    .ACCW (ACCW)
  ) u_merge (
    .acc_even (lane_acc[0]),
    .acc_odd  (lane_acc[1]),
    .result   (y_out)
  );

endmodule

// File: rtl/fir_pair_mac_chk.sv
module fir_pair_mac_chk #(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int HAW  = 4,
  parameter int CAW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           hist_we,
  input logic [HAW-1:0] hist_waddr,
  input logic           rd_en,
  input logic [CAW-1:0] coef_addr,
  input logic [HAW-1:0] smp_addr_lo,
  input logic [DW-1:0]  y_out,
  input logic           y_valid
);

  logic [15:0]    rd_cnt;
  logic [HAW-1:0] last_waddr;
  logic           seen_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt     <= '0;
      last_waddr <= '0;
      seen_we    <= 1'b0;
    end else begin
      if (hist_we) begin
        rd_cnt     <= '0;
        last_waddr <= hist_waddr;
        seen_we    <= 1'b1;
      end else if (rd_en) begin
        rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  // R7
  valid_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_en) |=> y_valid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !hist_we) |=> $stable(y_out));

  // R5
  write_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |-> start);

  // R5
  write_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_we && seen_we) |-> (hist_waddr == HAW'(last_waddr + 1'b1)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && start) |-> !hist_we);

  // R4
  first_read_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |=> (rd_en && (smp_addr_lo == $past(hist_waddr)) && (coef_addr == '0)));

  // R4
  read_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (smp_addr_lo == HAW'($past(smp_addr_lo) - HAW'(2))));

  // R3
  read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (rd_cnt == 16'(TAPS / 2)));

endmodule

bind fir_pair_mac fir_pair_mac_chk #(
  .TAPS (TAPS),
  .DW   (DW),
  .HAW  (HAW),
  .CAW  (CAW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .hist_we     (hist_we),
  .hist_waddr  (hist_waddr),
  .rd_en       (rd_en),
  .coef_addr   (coef_addr),
  .smp_addr_lo (smp_addr_lo),
  .y_out       (y_out),
  .y_valid     (y_valid)
);

// File: tb/test_fir_pair_mac.sv
module test_fir_pair_mac;

  localparam int TAPS  = 8;
  localparam int DW    = 16;
  localparam int HAW   = 4;
  localparam int HALF  = TAPS / 2;
  localparam int CAW   = 2;
  localparam int DEPTH = 1 << HAW;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [DW-1:0]   sample_in;
  logic            hist_we;
  logic [HAW-1:0]  hist_waddr;
  logic [DW-1:0]   hist_wdata;
  logic            rd_en;
  logic [CAW-1:0]  coef_addr;
  logic [2*DW-1:0] coef_rdata;
  logic [HAW-1:0]  smp_addr_lo;
  logic [HAW-1:0]  smp_addr_hi;
  logic [2*DW-1:0] smp_rdata;
  logic [DW-1:0]   y_out;
  logic            y_valid;

  fir_pair_mac #(.TAPS(TAPS), .DW(DW), .HAW(HAW), .ACCW(40)) i_fir_pair_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_in(sample_in),
    .hist_we(hist_we), .hist_waddr(hist_waddr), .hist_wdata(hist_wdata),
    .rd_en(rd_en), .coef_addr(coef_addr), .coef_rdata(coef_rdata),
    .smp_addr_lo(smp_addr_lo), .smp_addr_hi(smp_addr_hi), .smp_rdata(smp_rdata),
    .y_out(y_out), .y_valid(y_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Memory models: one-cycle registered reads (R1).
  logic [DW-1:0]   hist_mem [DEPTH];
  logic [2*DW-1:0] coef_mem [HALF];

  always @(posedge clk) begin
    if (hist_we) hist_mem[hist_waddr] <= hist_wdata;
    if (rd_en) begin
      smp_rdata  <= {hist_mem[smp_addr_hi], hist_mem[smp_addr_lo]};
      coef_rdata <= coef_mem[coef_addr];
    end
  end

  int    n_checks;
  int    n_fail;
  bit    finished;
  string cur_req;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int     hq[$];
  int     cd;
  bit     armed;
  int     head;
  int     op_head;
  longint exp_y;

  function automatic int tap(input int j);
    logic [2*DW-1:0] w;
    w = coef_mem[j / 2];
    return (j % 2 == 0) ? int'($signed(w[DW-1:0])) : int'($signed(w[2*DW-1:DW]));
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      // R10
      chk("R10", "y_valid in reset", longint'(y_valid), 0);
      chk("R10", "rd_en in reset", longint'(rd_en), 0);
      chk("R10", "hist_we in reset", longint'(hist_we), 0);
      hq.delete();
      cd = 0; armed = 0; head = 0; op_head = 0; exp_y = 0;
    end else begin
      bit exp_v;
      bit exp_rd;
      if (cd > 0) cd--;
      exp_v = armed && (cd == 0);
      if (exp_v) armed = 0;
      chk("R7", "y_valid", longint'(y_valid), longint'(exp_v));
      if (exp_v) chk(cur_req, "y_out", longint'(y_out), exp_y & 16'hFFFF);
      exp_rd = armed && (cd >= 2) && (cd <= HALF + 1);
      chk("R3", "rd_en", longint'(rd_en), longint'(exp_rd));
      if (exp_rd && rd_en) begin
        int i;
        i = HALF + 1 - cd;
        chk("R3", "coef_addr", longint'(coef_addr), longint'(i));
        chk("R4", "smp_addr_lo", longint'(smp_addr_lo), longint'((op_head - 2 * i) & (DEPTH - 1)));
        chk("R4", "smp_addr_hi", longint'(smp_addr_hi), longint'((op_head - 2 * i - 1) & (DEPTH - 1)));
      end
      if (start && !armed) begin
        chk("R5", "hist_we on accept", longint'(hist_we), 1);
        chk("R5", "hist_waddr", longint'(hist_waddr), longint'(head));
        chk("R5", "hist_wdata", longint'(hist_wdata), longint'(sample_in));
        hq.push_front(int'($signed(sample_in)));
        if (hq.size() > 64) void'(hq.pop_back());
        exp_y = 0;
        for (int j = 0; j < TAPS; j++) begin
          if (j < hq.size()) exp_y += longint'(tap(j)) * longint'(hq[j]);
        end
        op_head = head;
        head = (head + 1) % DEPTH;
        armed = 1;
        cd = HALF + 2;
      end else begin
        chk(start ? "R8" : "R5", "hist_we idle/busy", longint'(hist_we), 0);
      end
    end
  end

  task automatic one_op(input logic [DW-1:0] v);
    @(posedge clk); #1;
    start = 1'b1; sample_in = v;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (HALF + 4) @(posedge clk);
  endtask

  task automatic set_coef(input int t0, input int t1, input int t2, input int t3,
                          input int t4, input int t5, input int t6, input int t7);
    coef_mem[0] = {16'(t1), 16'(t0)};
    coef_mem[1] = {16'(t3), 16'(t2)};
    coef_mem[2] = {16'(t5), 16'(t4)};
    coef_mem[3] = {16'(t7), 16'(t6)};
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) hist_mem[k] = '0;
    n_checks = 0; n_fail = 0; finished = 0;
    cur_req = "R9";
    start = 1'b0; sample_in = '0; rst_n = 1'b0;
    set_coef(2, 1, 1, 1, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R9: four-tap weighting 2,1,1,1
    for (int k = 1; k <= 6; k++) one_op(16'(k * 3));

    // R2 / R6: signed mixed taps, enough outputs to wrap the write pointer (R5)
    cur_req = "R6";
    set_coef(-3, 5, 7, -11, 13, -17, 19, -23);
    for (int k = 0; k < 20; k++) one_op(16'($urandom));

    // R6: large magnitudes, result exceeds 32 bits and is truncated
    set_coef(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767);
    for (int k = 0; k < 9; k++) one_op(16'h7FFF);
    set_coef(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768);
    for (int k = 0; k < 9; k++) one_op(16'h8000);

    // R8: start held high, busy requests dropped, valid-cycle request taken
    cur_req = "R8";
    set_coef(1, -2, 3, -4, 5, -6, 7, -8);
    @(posedge clk); #1;
    start = 1'b1;
    for (int k = 0; k < 5 * (HALF + 2); k++) begin
      sample_in = 16'(k * 101 - 700);
      @(posedge clk); #1;
    end
    start = 1'b0;
    repeat (HALF + 6) @(posedge clk);

    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule